// File: doc/BRIEF.md
# Add/Subtract Flag Unit

This block is the arithmetic core of a small integer datapath. One ripple-carry binary adder does every operation it supports: add, add with carry, subtract, subtract with borrow and compare. For the subtract-class operations the second operand is inverted bit by bit and the adder's carry input is adjusted. Every status flag is taken from the adder's internal carries or from its sum, so no extra comparator or subtractor is needed.

An operation is issued by holding `op_valid` high for one clock with an operation code and two operands. On that clock edge the result register and the flag register update, as that operation allows. The stored carry flag feeds back into the adder, so multi-byte additions and subtractions chain one byte per operation. The signed less-than output comes from sign XOR overflow, so after a compare it gives a signed ordering of the two operands.

Top module: `addsub_flag_unit`

## Requirements
- R1: A low `rst_n` clears the result register, all flags and `less_than` at once, without waiting for a clock. The internal reset is released two rising clock edges after `rst_n` goes high, and operations are accepted only after that.
- R2: Operation code 3'd0 (add) writes (A + B) mod 256 to `result` and sets `flag_carry` to the carry out of bit 7.
- R3: Operation code 3'd1 (add with carry) writes (A + B + C) mod 256, where C is the stored `flag_carry`, and sets `flag_carry` to the carry out of bit 7.
- R4: Operation code 3'd2 (subtract) writes (A − B) mod 256 and sets `flag_carry` to the borrow, which is 1 exactly when A < B unsigned.
- R5: Operation code 3'd3 (subtract with borrow) writes (A − B − C) mod 256, where C is the stored `flag_carry`, and sets `flag_carry` to 1 exactly when A < B + C.
- R6: Operation code 3'd4 (compare) updates every flag exactly as subtract would, and leaves `result` unchanged.
- R7: `flag_ovf` is 1 exactly when the signed (two's complement) value of the operation lies outside −128..127. In the adder this is the carry out of bit 7 XOR the carry out of bit 6.
- R8: For add-class operations, `flag_aux` is the carry out of bit 3. For subtract-class operations it is the borrow out of the low nibble, which is the inverted carry out of bit 3.
- R9: `flag_sign` is bit 7 of the adder sum. `flag_zero` is 1 when the sum is zero. `flag_parity` is 1 when the sum has an even number of one bits. For a compare, the sum is the difference.
- R10: `less_than` equals `flag_sign` XOR `flag_ovf`, so after a compare it is 1 exactly when A < B as signed numbers.
- R11: When `op_valid` is low, or when the operation code is 3'd5, 3'd6 or 3'd7, neither `result` nor any flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issues an operation on this clock edge |
| op_sel | input | 3 | Operation code (0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare) |
| opnd_a | input | 8 | First operand A |
| opnd_b | input | 8 | Second operand B |
| result | output | 8 | Registered result |
| flag_carry | output | 1 | Carry after add class, borrow after subtract class |
| flag_aux | output | 1 | Nibble carry or nibble borrow |
| flag_sign | output | 1 | Bit 7 of the last sum |
| flag_zero | output | 1 | Last sum was zero |
| flag_parity | output | 1 | Last sum had even parity |
| flag_ovf | output | 1 | Signed overflow |
| less_than | output | 1 | Signed less-than, sign XOR overflow |

## Verification
On every cycle the assertions check several relations. Idle cycles and reserved codes leave all state unchanged. A compare never touches the result. Plain add and subtract produce the exact wrapped sum or difference and the right carry or borrow. Sign, zero and parity agree with the written result, and the less-than register agrees with sign XOR overflow. Other behaviour is shown only by the bench's scenarios, which model the full arithmetic on their own: the carry chaining through add with carry and subtract with borrow over several bytes, the nibble borrow, the signed overflow boundaries at 0x7F/0x80, the signed ordering after compares, and the asynchronous clear in the middle of a run.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_ADC = 3'd1;
  localparam logic [2:0] OP_SUB = 3'd2;
  localparam logic [2:0] OP_SBB = 3'd3;
  localparam logic [2:0] OP_CMP = 3'd4;

  typedef struct packed {
    logic carry;
    logic aux;
    logic sign;
    logic zero;
    logic parity;
    logic ovf;
    logic lt;
  } flags_t;

  typedef struct packed {
    logic invert_b;       // feed ~B into the adder
    logic cin_from_flag;  // carry input taken from stored carry flag
    logic cin_const;      // carry input when not taken from the flag
    logic is_sub;         // subtract class: borrow convention on carries
    logic wr_result;
    logic wr_flags;
  } ctrl_t;

endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= {shreg_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = shreg_q[STAGES-1];
endmodule

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (ci & (a ^ b));
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic [W-1:0] cout   // cout[i] = carry out of bit i
);
  logic [W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    fa_cell u_fa (
      .a  (a[i]),
      .b  (b[i]),
      .ci (chain[i]),
      .s  (sum[i]),
      .co (chain[i+1])
    );
  end

  assign cout = chain[W:1];
endmodule

// File: rtl/op_decode.sv
module op_decode
  import addsub_pkg::*;
(
  input  logic       op_valid,
  input  logic [2:0] op_sel,
  output ctrl_t      ctrl
);
  ctrl_t base;

  always_comb begin
    base = '0;
    unique case (op_sel)
      OP_ADD: begin
        base.wr_result = 1'b1;
        base.wr_flags  = 1'b1;
      end
      OP_ADC: begin
        base.cin_from_flag = 1'b1;
        base.wr_result     = 1'b1;
        base.wr_flags      = 1'b1;
      end
      OP_SUB: begin
        base.invert_b  = 1'b1;
        base.cin_const = 1'b1;
        base.is_sub    = 1'b1;
        base.wr_result = 1'b1;
        base.wr_flags  = 1'b1;
      end
      OP_SBB: begin
        base.invert_b      = 1'b1;
        base.cin_from_flag = 1'b1;
        base.is_sub        = 1'b1;
        base.wr_result     = 1'b1;
        base.wr_flags      = 1'b1;
      end
      OP_CMP: begin
        base.invert_b  = 1'b1;
        base.cin_const = 1'b1;
        base.is_sub    = 1'b1;
        base.wr_flags  = 1'b1;
      end
      default: base = '0;
    endcase
  end

  always_comb begin
    ctrl = base;
    ctrl.wr_result = base.wr_result & op_valid;
    ctrl.wr_flags  = base.wr_flags  & op_valid;
  end
endmodule

// File: rtl/flag_gen.sv
module flag_gen
  import addsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] sum,
  input  logic [W-1:0] cout,
  input  logic         is_sub,
  output flags_t       nxt
);
  localparam int NIB_TOP = W / 2 - 1;

  logic ovf;

  assign ovf = cout[W-1] ^ cout[W-2];

  always_comb begin
    nxt.carry  = cout[W-1] ^ is_sub;
    nxt.aux    = cout[NIB_TOP] ^ is_sub;
    nxt.sign   = sum[W-1];
    nxt.zero   = ~|sum;
    nxt.parity = ~^sum;
    nxt.ovf    = ovf;
    nxt.lt     = sum[W-1] ^ ovf;
  end
endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit
  import addsub_pkg::*;
#(
  parameter int W          = 8,
  parameter int RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic         flag_carry,
  output logic         flag_aux,
  output logic         flag_sign,
  output logic         flag_zero,
  output logic         flag_parity,
  output logic         flag_ovf,
  output logic         less_than
);
  logic         rst_core_n;
  ctrl_t        ctrl;
  logic [W-1:0] b_eff;
  logic         cin;
  logic [W-1:0] sum;
  logic [W-1:0] cout;
  flags_t       flg_nxt;

  logic [W-1:0] res_q, res_d;
  flags_t       flg_q, flg_d;

  rstgen_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  op_decode u_dec (
    .op_valid (op_valid),
    .op_sel   (op_sel),
    .ctrl     (ctrl)
  );

  // operand conditioning: subtract class adds the one's complement of B
  assign b_eff = ctrl.invert_b ? ~opnd_b : opnd_b;
  // stored borrow becomes an inverted carry for subtract with borrow
  assign cin   = ctrl.cin_from_flag ? (flg_q.carry ^ ctrl.is_sub) : ctrl.cin_const;

  ripple_chain #(.W(W)) u_add (
    .a    (opnd_a),
    .b    (b_eff),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
  );

  flag_gen #(.W(W)) u_flg (
    .sum    (sum),
    .cout   (cout),
    .is_sub (ctrl.is_sub),
    .nxt    (flg_nxt)
  );

  always_comb begin
    res_d = res_q;
    flg_d = flg_q;
    if (ctrl.wr_result) res_d = sum;
    if (ctrl.wr_flags)  flg_d = flg_nxt;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      res_q <= '0;
      flg_q <= '0;
    end else begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign result      = res_q;
  assign flag_carry  = flg_q.carry;
  assign flag_aux    = flg_q.aux;
  assign flag_sign   = flg_q.sign;
  assign flag_zero   = flg_q.zero;
  assign flag_parity = flg_q.parity;
  assign flag_ovf    = flg_q.ovf;
  assign less_than   = flg_q.lt;
endmodule

// File: rtl/addsub_flag_unit_chk.sv
module addsub_flag_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_core_n,
  input logic         op_valid,
  input logic [2:0]   op_sel,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] result,
  input logic         flag_carry,
  input logic         flag_aux,
  input logic         flag_sign,
  input logic         flag_zero,
  input logic         flag_parity,
  input logic         flag_ovf,
  input logic         less_than
);
  logic [6:0] flags_all;
  assign flags_all = {flag_carry, flag_aux, flag_sign, flag_zero, flag_parity, flag_ovf, less_than};

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    !op_valid |=> ($stable(result) && $stable(flags_all)));

  assert_reserved_hold_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op_valid && op_sel > 3'd4) |=> ($stable(result) && $stable(flags_all)));

  assert_cmp_keeps_result_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op_valid && op_sel == 3'd4) |=> $stable(result));

  assert_add_sum_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op_valid && op_sel == 3'd0) |=>
      ({flag_carry, result} == ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)})));

  assert_sub_diff_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op_valid && op_sel == 3'd2) |=>
      ((result == W'($past(opnd_a) - $past(opnd_b))) && (flag_carry == ($past(opnd_a) < $past(opnd_b)))));

  assert_sign_zero_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op_valid && op_sel < 3'd4) |=>
      ((flag_sign == result[W-1]) && (flag_zero == (result == '0)) && (flag_parity == ~^result)));

  assert_lt_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    less_than == (flag_sign ^ flag_ovf));
endmodule

bind addsub_flag_unit addsub_flag_unit_chk #(.W(W)) i_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .op_valid    (op_valid),
  .op_sel      (op_sel),
  .opnd_a      (opnd_a),
  .opnd_b      (opnd_b),
  .result      (result),
  .flag_carry  (flag_carry),
  .flag_aux    (flag_aux),
  .flag_sign   (flag_sign),
  .flag_zero   (flag_zero),
  .flag_parity (flag_parity),
  .flag_ovf    (flag_ovf),
  .less_than   (less_than)
);

// File: tb/test_addsub_flag_unit.sv
module test_addsub_flag_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [2:0] op_sel;
  logic [7:0] opnd_a, opnd_b;
  logic [7:0] result;
  logic flag_carry, flag_aux, flag_sign, flag_zero, flag_parity, flag_ovf, less_than;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [7:0] res;
    logic cf, af, sf, zf, pf, of, lt;
    string req;
  } exp_t;

  exp_t q[$];
  exp_t m;

  always #(CLK_PERIOD/2) clk = ~clk;

  addsub_flag_unit i_addsub_flag_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .flag_carry(flag_carry), .flag_aux(flag_aux), .flag_sign(flag_sign),
    .flag_zero(flag_zero), .flag_parity(flag_parity), .flag_ovf(flag_ovf),
    .less_than(less_than)
  );

  task automatic chk(input string what, input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input exp_t e);
    chk("result", e.req, result, e.res);
    chk("carry",  e.req, {7'd0, flag_carry},  {7'd0, e.cf});
    chk("aux",    e.req, {7'd0, flag_aux},    {7'd0, e.af});
    chk("sign",   e.req, {7'd0, flag_sign},   {7'd0, e.sf});
    chk("zero",   e.req, {7'd0, flag_zero},   {7'd0, e.zf});
    chk("parity", e.req, {7'd0, flag_parity}, {7'd0, e.pf});
    chk("ovf",    e.req, {7'd0, flag_ovf},    {7'd0, e.of});
    chk("lt R10", e.req, {7'd0, less_than},   {7'd0, e.lt});
  endtask

  task automatic clear_model();
    m.res = 8'h00; m.cf = 0; m.af = 0; m.sf = 0; m.zf = 0; m.pf = 0; m.of = 0; m.lt = 0;
  endtask

  // driver: computes the expected outcome from the requirements and queues it
  task automatic do_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b, input string req);
    exp_t e;
    int c, full, sv, nib;
    logic [7:0] r;
    @(negedge clk);
    e = m;
    if (op <= 3'd4) begin
      c = (op == 3'd1 || op == 3'd3) ? int'(m.cf) : 0;
      if (op <= 3'd1) begin
        full = int'(a) + int'(b) + c;
        nib  = int'(a & 8'h0f) + int'(b & 8'h0f) + c;
        sv   = int'($signed(a)) + int'($signed(b)) + c;
        e.cf = (full > 255);
        e.af = (nib > 15);
      end else begin
        full = int'(a) - int'(b) - c;
        nib  = int'(a & 8'h0f) - int'(b & 8'h0f) - c;
        sv   = int'($signed(a)) - int'($signed(b)) - c;
        e.cf = (full < 0);
        e.af = (nib < 0);
      end
      r    = full[7:0];
      e.of = (sv > 127) || (sv < -128);
      e.sf = r[7];
      e.zf = (r == 8'h00);
      e.pf = ~^r;
      e.lt = e.sf ^ e.of;
      if (op != 3'd4) e.res = r;
    end
    e.req = req;
    m = e;
    q.push_back(e);
    op_valid = 1'b1;
    op_sel   = op;
    opnd_a   = a;
    opnd_b   = b;
  endtask

  task automatic idle_check(input string req);
    exp_t e;
    @(negedge clk);
    op_valid = 1'b0;
    op_sel   = 3'd0;
    opnd_a   = 8'hA5;
    opnd_b   = 8'h5A;
    @(negedge clk);
    e = m;
    e.req = req;
    chk_state(e);
  endtask

  // monitor: pops one expected item per issued operation
  initial begin
    forever begin
      @(posedge clk);
      if (op_valid === 1'b1 && rst_n === 1'b1) begin
        @(negedge clk);
        if (q.size() == 0) begin
          total++; bad++;
          $display("FAIL monitor: actual=result with empty queue expected=queued item");
        end else begin
          chk_state(q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    exp_t z;
    rst_n = 1'b0; op_valid = 1'b0; op_sel = 3'd0; opnd_a = 8'h00; opnd_b = 8'h00;
    clear_model();
    repeat (3) @(negedge clk);
    z = m; z.req = "R1";
    chk_state(z);                           // R1 reset state
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    do_op(3'd0, 8'h7F, 8'h01, "R2 R7");     // 0x80, signed overflow, nibble carry
    do_op(3'd0, 8'hFF, 8'h01, "R2 R9");     // wrap to zero, carry out
    do_op(3'd1, 8'h00, 8'h00, "R3");        // carry in from flag -> 0x01
    do_op(3'd1, 8'h10, 8'h20, "R3");
    do_op(3'd0, 8'h0F, 8'h01, "R8");        // nibble carry only
    do_op(3'd2, 8'h05, 8'h03, "R4");
    do_op(3'd2, 8'h03, 8'h05, "R4 R8");     // borrow, nibble borrow
    do_op(3'd3, 8'h00, 8'h00, "R5");        // borrow in -> 0xFF, borrow out
    do_op(3'd3, 8'h10, 8'h0F, "R5");
    do_op(3'd2, 8'h80, 8'h01, "R7 R10");    // -128 - 1 overflows
    do_op(3'd4, 8'hFF, 8'h01, "R6 R10");    // -1 < 1 signed
    do_op(3'd4, 8'h01, 8'hFF, "R6 R10");
    do_op(3'd4, 8'h42, 8'h42, "R6 R9");
    do_op(3'd4, 8'h7F, 8'h80, "R6 R7");     // 127 vs -128
    do_op(3'd5, 8'h12, 8'h34, "R11");
    do_op(3'd6, 8'hFF, 8'hFF, "R11");
    do_op(3'd7, 8'h01, 8'h01, "R11");
    idle_check("R11");

    // two-byte chains
    do_op(3'd0, 8'hFF, 8'h01, "R2 chain");
    do_op(3'd1, 8'h12, 8'h00, "R3 chain");  // 0x12FF + 0x0001 -> 0x13
    do_op(3'd2, 8'h00, 8'h01, "R4 chain");
    do_op(3'd3, 8'h13, 8'h00, "R5 chain");  // 0x1300 - 0x0001 -> 0x12

    for (int i = 0; i < 60; i++) begin
      do_op(3'(i % 5), 8'(i * 37 + 5), 8'(i * 91 + 11), "R9 sweep");
    end
    idle_check("R11");

    // asynchronous clear mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    clear_model();
    z = m; z.req = "R1 async";
    chk_state(z);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_op(3'd1, 8'h01, 8'h01, "R1 R3");     // carry cleared by reset -> 0x02
    idle_check("R11");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule